// File: doc/BRIEF.md
# DMA Block Transfer Sequencer

This block is the address and count engine for a pair of DMA channels that run in block mode. Software sets a source start address, a destination start address, a step mode for each pointer, an element width (byte or word), a block size M and a block count N, then pulses `arm`. Each later request strobe starts one burst. The burst moves M elements back to back, and each element finishes on a single-cycle bus acknowledge. After the burst the engine waits for the next request. When the N-th block is finished, the job is complete.

One of the two pointers is chosen as the block area. At the end of every block that pointer returns to its start address. The other pointer keeps moving across block boundaries. This lets a block be copied repeatedly into a fixed window, or read repeatedly from one. An 8-bit working counter counts elements and reloads from a held copy of M after each block. A 16-bit counter counts the blocks that remain.

Top module: `blkxfer_seq`

## Requirements
- R1: After reset the engine is stopped and ignores `reqPulse` until `arm` is pulsed. An `arm` cycle latches both start addresses, both pointer modes, `wordSize`, `blockOnDst`, M and N, and it clears `allDone` and any pending request. `arm` takes priority over every other input.
- R2: `xferStb` rises in the cycle after a request is sampled in the waiting state. It stays high for exactly M completed elements, where `blkSizeCfg` = 0 encodes M = 256. The engine then drops `xferStb` and waits. Every block of a job has the same M.
- R3: After each completed element a pointer steps according to its mode: 2'b01 increments, 2'b10 decrements, and 2'b00 or 2'b11 holds. The step is 1 when `wordSize` = 0 and 2 when `wordSize` = 1. Addresses are 24 bits wide and wrap modulo 2^24.
- R4: With `blockOnDst` = 1 the destination pointer is the block area, and with 0 the source pointer is. At the end of each block the block-area pointer reloads its start address, and the other pointer keeps its stepped value.
- R5: `blockDone` is high for exactly one cycle: the cycle after the edge at which the last element of a block completed.
- R6: After N blocks, where `blkCountCfg` = 0 encodes N = 65536, `allDone` rises together with the final `blockDone`. `xferStb` then stays low and requests are ignored until the next `arm`.
- R7: Any number of requests that arrive while a block is running are held as one pending flag. That flag starts exactly one more block once the current block ends.
- R8: An element completes only at an edge where `xferStb` and `busAck` are both high. `busAck` while `xferStb` is low changes nothing, and a low `busAck` during a block stalls both pointers.
- R9: Synchronous active-high `rst` stops the engine. It clears both counters, the pending flag, `blockDone`, `allDone` and both pointers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Load configuration and start a new job |
| reqPulse | input | 1 | Transfer request, one block per request |
| busAck | input | 1 | Element completes this cycle |
| srcStart | input | 24 | Source start address |
| dstStart | input | 24 | Destination start address |
| srcMode | input | 2 | Source step mode (01 inc, 10 dec, 00/11 hold) |
| dstMode | input | 2 | Destination step mode (same encoding) |
| wordSize | input | 1 | 0 byte step of 1, 1 word step of 2 |
| blockOnDst | input | 1 | 1: destination is block area, 0: source is |
| blkSizeCfg | input | 8 | Elements per block, 0 means 256 |
| blkCountCfg | input | 16 | Number of blocks, 0 means 65536 |
| srcAddr | output | 24 | Current source address |
| dstAddr | output | 24 | Current destination address |
| xferStb | output | 1 | Element transfer strobe |
| blockDone | output | 1 | One-cycle pulse after each block |
| allDone | output | 1 | Job complete |

## Verification
The bench exercises the encoded sizes M = 256 and N = 65536. A design that read these encodings as zero would end at once or never end, and would show the wrong number of strobes or `blockDone` pulses. It sends a burst of requests in the middle of a block and expects exactly one extra block. A design that counted requests would run too many blocks, and one that dropped them would stall. It also wraps a pointer past both ends of the 24-bit space, holds `busAck` high while the engine waits, and stalls elements by lowering `busAck`. These cases expose mis-sized steps, moves that should not happen, and a block-area pointer that fails to reload or reloads the wrong side.

// File: rtl/blkxfer_pkg.sv
package blkxfer_pkg;

  typedef enum logic [1:0] {
    PTR_FIXED = 2'b00,
    PTR_INC   = 2'b01,
    PTR_DEC   = 2'b10,
    PTR_HOLD  = 2'b11
  } ptrMode_e;

  typedef enum logic [1:0] {
    ST_OFF  = 2'b00,
    ST_WAIT = 2'b01,
    ST_RUN  = 2'b10
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // latch configuration
    logic step;      // one element completed
    logic blockEnd;  // that element closed the block
  } dpCtrl_t;

endpackage

// File: rtl/blkxfer_ptr.sv
module blkxfer_ptr
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic              restore,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [1:0]        mode,
  input  logic              wordSize,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] baseQ;
  ptrMode_e          modeQ;
  logic              wordQ;
  logic [ADDR_W-1:0] stepAmt;
  logic [ADDR_W-1:0] addrNext;

  assign stepAmt = wordQ ? ADDR_W'(2) : ADDR_W'(1);

  always_comb begin
    unique case (modeQ)
      PTR_INC: addrNext = addr + stepAmt;
      PTR_DEC: addrNext = addr - stepAmt;
      default: addrNext = addr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr  <= '0;
      baseQ <= '0;
      modeQ <= PTR_FIXED;
      wordQ <= 1'b0;
    end else if (load) begin
      addr  <= startAddr;
      baseQ <= startAddr;
      modeQ <= ptrMode_e'(mode);
      wordQ <= wordSize;
    end else if (step) begin
      addr  <= restore ? baseQ : addrNext;
    end
  end

  AST_AREA_RESTORE: assert property (@(posedge clk) disable iff (rst)
    (restore && step && !load) |=> (addr == baseQ)) else $error("block area not restored"); // R4

  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (step && !restore && !load && (modeQ == PTR_FIXED || modeQ == PTR_HOLD)) |=> $stable(addr))
    else $error("fixed pointer moved"); // R3

  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(addr)) else $error("pointer moved without element"); // R8

endmodule

// File: rtl/blkxfer_dp.sv
module blkxfer_dp
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtrl_t           ctl,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  input  logic [1:0]        srcMode,
  input  logic [1:0]        dstMode,
  input  logic              wordSize,
  input  logic              blockOnDst,
  input  logic [SIZE_W-1:0] blkSizeCfg,
  input  logic [CNT_W-1:0]  blkCountCfg,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              lastElem,
  output logic              lastBlock
);

  localparam int NUM_PTR = 2;

  logic [SIZE_W-1:0] holdSize;
  logic [SIZE_W-1:0] sizeCnt;
  logic [CNT_W-1:0]  blkCnt;
  logic              onDstQ;

  logic [NUM_PTR-1:0][ADDR_W-1:0] startArr;
  logic [NUM_PTR-1:0][1:0]        modeArr;
  logic [NUM_PTR-1:0][ADDR_W-1:0] addrArr;
  logic [NUM_PTR-1:0]             isArea;

  assign startArr = {dstStart, srcStart};
  assign modeArr  = {dstMode, srcMode};
  assign isArea   = {onDstQ, !onDstQ};
  assign srcAddr  = addrArr[0];
  assign dstAddr  = addrArr[1];

  for (genvar g = 0; g < NUM_PTR; g++) begin : g_ptr
    blkxfer_ptr #(.ADDR_W(ADDR_W)) u_ptr (
      .clk       (clk),
      .rst       (rst),
      .load      (ctl.load),
      .step      (ctl.step),
      .restore   (ctl.blockEnd && isArea[g]),
      .startAddr (startArr[g]),
      .mode      (modeArr[g]),
      .wordSize  (wordSize),
      .addr      (addrArr[g])
    );
  end

  assign lastElem  = (sizeCnt == SIZE_W'(1));
  assign lastBlock = (blkCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      holdSize <= '0;
      sizeCnt  <= '0;
      blkCnt   <= '0;
      onDstQ   <= 1'b0;
    end else if (ctl.load) begin
      holdSize <= blkSizeCfg;
      sizeCnt  <= blkSizeCfg;
      blkCnt   <= blkCountCfg;
      onDstQ   <= blockOnDst;
    end else if (ctl.step) begin
      if (ctl.blockEnd) begin
        sizeCnt <= holdSize;
        blkCnt  <= blkCnt - CNT_W'(1);
      end else begin
        sizeCnt <= sizeCnt - SIZE_W'(1);
      end
    end
  end

  AST_HOLD_FIXED: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(holdSize)) else $error("held size changed"); // R2

  AST_SIZE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (ctl.step && ctl.blockEnd && !ctl.load) |=> (sizeCnt == holdSize)) else $error("size not reloaded"); // R2

  AST_BLK_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!ctl.blockEnd && !ctl.load) |=> $stable(blkCnt)) else $error("block count moved mid-block"); // R6

endmodule

// File: rtl/blkxfer_ctrl.sv
module blkxfer_ctrl
  import blkxfer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    arm,
  input  logic    reqPulse,
  input  logic    busAck,
  input  logic    lastElem,
  input  logic    lastBlock,
  output dpCtrl_t ctl,
  output logic    xferStb,
  output logic    blockDone,
  output logic    allDone
);

  seqState_e state;
  logic      pending;

  assign xferStb      = (state == ST_RUN);
  assign ctl.load     = arm;
  assign ctl.step     = xferStb && busAck && !arm;
  assign ctl.blockEnd = ctl.step && lastElem;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_OFF;
      pending   <= 1'b0;
      blockDone <= 1'b0;
      allDone   <= 1'b0;
    end else begin
      blockDone <= 1'b0;
      if (arm) begin
        state   <= ST_WAIT;
        pending <= 1'b0;
        allDone <= 1'b0;
      end else begin
        unique case (state)
          ST_WAIT: begin
            if (reqPulse || pending) begin
              state   <= ST_RUN;
              pending <= 1'b0;
            end
          end
          ST_RUN: begin
            if (reqPulse) pending <= 1'b1;
            if (ctl.blockEnd) begin
              blockDone <= 1'b1;
              if (lastBlock) begin
                allDone <= 1'b1;
                state   <= ST_OFF;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    blockDone |=> !blockDone) else $error("block pulse too long"); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    allDone |-> !xferStb) else $error("strobe after job end"); // R6

  AST_ALL_WITH_BLOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(allDone) |-> blockDone) else $error("job end without block end"); // R6

  AST_PEND_ONE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && pending && !arm) |=> xferStb) else $error("pending request lost"); // R7

endmodule

// File: rtl/blkxfer_seq.sv
module blkxfer_seq
  import blkxfer_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              reqPulse,
  input  logic              busAck,
  input  logic [ADDR_W-1:0] srcStart,
  input  logic [ADDR_W-1:0] dstStart,
  input  logic [1:0]        srcMode,
  input  logic [1:0]        dstMode,
  input  logic              wordSize,
  input  logic              blockOnDst,
  input  logic [SIZE_W-1:0] blkSizeCfg,
  input  logic [CNT_W-1:0]  blkCountCfg,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic              xferStb,
  output logic              blockDone,
  output logic              allDone
);

  dpCtrl_t ctl;
  logic    lastElem;
  logic    lastBlock;

  blkxfer_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .reqPulse  (reqPulse),
    .busAck    (busAck),
    .lastElem  (lastElem),
    .lastBlock (lastBlock),
    .ctl       (ctl),
    .xferStb   (xferStb),
    .blockDone (blockDone),
    .allDone   (allDone)
  );

  blkxfer_dp #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctl         (ctl),
    .srcStart    (srcStart),
    .dstStart    (dstStart),
    .srcMode     (srcMode),
    .dstMode     (dstMode),
    .wordSize    (wordSize),
    .blockOnDst  (blockOnDst),
    .blkSizeCfg  (blkSizeCfg),
    .blkCountCfg (blkCountCfg),
    .srcAddr     (srcAddr),
    .dstAddr     (dstAddr),
    .lastElem    (lastElem),
    .lastBlock   (lastBlock)
  );

endmodule

// File: tb/blkxfer_seq_tb.sv
`timescale 1ns/1ps
module blkxfer_seq_tb;

  logic        clk = 1'b0;
  logic        rst, arm, reqPulse, busAck;
  logic [23:0] srcStart, dstStart;
  logic [1:0]  srcMode, dstMode;
  logic        wordSize, blockOnDst;
  logic [7:0]  blkSizeCfg;
  logic [15:0] blkCountCfg;
  logic [23:0] srcAddr, dstAddr;
  logic        xferStb, blockDone, allDone;

  always #4 clk = ~clk;

  blkxfer_seq u_dut (
    .clk(clk), .rst(rst), .arm(arm), .reqPulse(reqPulse), .busAck(busAck),
    .srcStart(srcStart), .dstStart(dstStart), .srcMode(srcMode), .dstMode(dstMode),
    .wordSize(wordSize), .blockOnDst(blockOnDst), .blkSizeCfg(blkSizeCfg),
    .blkCountCfg(blkCountCfg), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .xferStb(xferStb), .blockDone(blockDone), .allDone(allDone)
  );

  int checks = 0;
  int fails  = 0;
  int dutBlocks = 0;

  // reference model state: 0 off, 1 wait, 2 run
  int          mState;
  bit          mPend, mBlkDone, mAllDone, mOnDst, mWord;
  logic [1:0]  mSm, mDm;
  logic [23:0] mSrc, mDst, mSrcBase, mDstBase;
  int          mM, mLeft, mBlocks;

  typedef struct packed {
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic        wd;
    logic        onDst;
    logic [7:0]  sz;
    logic [15:0] cnt;
    logic [23:0] expSrc;
    logic [23:0] expDst;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 2'b01, 1'b0, 1'b1, 8'd4, 16'd3, 24'h00010C, 24'h000200},
    '{2'b10, 2'b01, 1'b1, 1'b0, 8'd3, 16'd2, 24'h000100, 24'h00020C},
    '{2'b00, 2'b10, 1'b0, 1'b0, 8'd2, 16'd2, 24'h000100, 24'h0001FC},
    '{2'b01, 2'b11, 1'b1, 1'b1, 8'd1, 16'd5, 24'h00010A, 24'h000200},
    '{2'b01, 2'b10, 1'b0, 1'b1, 8'd0, 16'd1, 24'h000200, 24'h000200}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] adv(input logic [23:0] cur, input logic [1:0] mode, input bit wd);
    logic [23:0] st;
    st = wd ? 24'd2 : 24'd1;
    case (mode)
      2'b01:   return cur + st;
      2'b10:   return cur - st;
      default: return cur;
    endcase
  endfunction

  task automatic compareAll();
    if (blockDone) dutBlocks++;
    check(xferStb == (mState == 2), "R2 xferStb", 32'(xferStb), 32'(mState == 2));
    check(srcAddr == mSrc, "R3 R4 srcAddr", 32'(srcAddr), 32'(mSrc));
    check(dstAddr == mDst, "R3 R4 dstAddr", 32'(dstAddr), 32'(mDst));
    check(blockDone == mBlkDone, "R5 blockDone", 32'(blockDone), 32'(mBlkDone));
    check(allDone == mAllDone, "R6 allDone", 32'(allDone), 32'(mAllDone));
  endtask

  // one clock: compare current outputs, drive inputs, predict next state
  task automatic cycle(input bit rq, input bit ak, input bit am);
    @(negedge clk);
    compareAll();
    reqPulse = rq; busAck = ak; arm = am;
    mBlkDone = 1'b0;
    if (am) begin
      mState = 1; mPend = 1'b0; mAllDone = 1'b0;
      mSrc = srcStart; mSrcBase = srcStart; mDst = dstStart; mDstBase = dstStart;
      mSm = srcMode; mDm = dstMode; mWord = wordSize; mOnDst = blockOnDst;
      mM = (blkSizeCfg == 0) ? 256 : int'(blkSizeCfg);
      mLeft = mM;
      mBlocks = (blkCountCfg == 0) ? 65536 : int'(blkCountCfg);
    end else if (mState == 1) begin
      if (rq || mPend) begin mState = 2; mPend = 1'b0; end
    end else if (mState == 2) begin
      if (rq) mPend = 1'b1;
      if (ak) begin
        mSrc = adv(mSrc, mSm, mWord);
        mDst = adv(mDst, mDm, mWord);
        mLeft--;
        if (mLeft == 0) begin
          if (mOnDst) mDst = mDstBase; else mSrc = mSrcBase;
          mLeft = mM;
          mBlkDone = 1'b1;
          mBlocks--;
          if (mBlocks == 0) begin mAllDone = 1'b1; mState = 0; end
          else mState = 1;
        end
      end
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; arm = 1'b0; reqPulse = 1'b0; busAck = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    mState = 0; mPend = 1'b0; mBlkDone = 1'b0; mAllDone = 1'b0;
    mSrc = '0; mDst = '0; mSrcBase = '0; mDstBase = '0;
    mSm = 2'b00; mDm = 2'b00; mWord = 1'b0; mOnDst = 1'b0; mM = 0; mLeft = 0; mBlocks = 0;
  endtask

  task automatic setCfg(input logic [23:0] s, input logic [23:0] d, input logic [1:0] sm,
                        input logic [1:0] dm, input bit wd, input bit od,
                        input logic [7:0] sz, input logic [15:0] cnt);
    srcStart = s; dstStart = d; srcMode = sm; dstMode = dm;
    wordSize = wd; blockOnDst = od; blkSizeCfg = sz; blkCountCfg = cnt;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    setCfg(24'h000100, 24'h000200, 2'b01, 2'b01, 1'b0, 1'b1, 8'd4, 16'd3);
    doReset();
    // R9 R1: reset state
    check(xferStb == 1'b0, "R9 xferStb after reset", 32'(xferStb), 0);
    check(allDone == 1'b0, "R9 allDone after reset", 32'(allDone), 0);
    check(srcAddr == 24'h0, "R9 srcAddr after reset", 32'(srcAddr), 0);
    // R1: request without arm ignored
    cycle(1, 1, 0);
    cycle(0, 1, 0);
    check(xferStb == 1'b0, "R1 request before arm", 32'(xferStb), 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      setCfg(24'h000100, 24'h000200, VECS[v].sm, VECS[v].dm, VECS[v].wd,
             VECS[v].onDst, VECS[v].sz, VECS[v].cnt);
      cycle(0, 1, 1);
      cycle(0, 1, 0);
      cycle(0, 1, 0);
      // R8: ack while waiting moves nothing
      check(srcAddr == 24'h000100, "R8 ack while waiting", 32'(srcAddr), 32'h100);
      while (!mAllDone) begin
        cycle(1, 1, 0);
        while (mState == 2) cycle(0, 1, 0);
      end
      cycle(0, 0, 0);
      check(srcAddr == VECS[v].expSrc, "R3 R4 final src", 32'(srcAddr), 32'(VECS[v].expSrc));
      check(dstAddr == VECS[v].expDst, "R3 R4 final dst", 32'(dstAddr), 32'(VECS[v].expDst));
    end

    // R7: burst of requests mid-block gives exactly one extra block; stalls via busAck (R8)
    setCfg(24'h000400, 24'h000800, 2'b01, 2'b01, 1'b0, 1'b0, 8'd3, 16'd3);
    cycle(0, 0, 1);
    dutBlocks = 0;
    cycle(1, 0, 0);
    cycle(1, 1, 0);
    cycle(1, 0, 0);
    cycle(1, 1, 0);
    cycle(0, 1, 0);
    for (int k = 0; k < 14; k++) cycle(0, k % 2, 0);
    cycle(0, 0, 0);
    check(dutBlocks == 2, "R7 blocks from request burst", 32'(dutBlocks), 2);
    check(allDone == 1'b0, "R6 not done after two of three", 32'(allDone), 0);
    cycle(1, 1, 0);
    while (mState == 2) cycle(0, 1, 0);
    cycle(0, 0, 0);
    check(allDone == 1'b1, "R6 done after three blocks", 32'(allDone), 1);

    // R3: 24-bit wrap in both directions
    setCfg(24'hFFFFFF, 24'h000000, 2'b01, 2'b10, 1'b1, 1'b0, 8'd2, 16'd1);
    cycle(0, 0, 1);
    cycle(1, 1, 0);
    while (mState == 2) cycle(0, 1, 0);
    cycle(0, 0, 0);
    check(dstAddr == 24'hFFFFFC, "R3 decrement wrap", 32'(dstAddr), 32'hFFFFFC);
    check(srcAddr == 24'hFFFFFF, "R4 source area restored", 32'(srcAddr), 32'hFFFFFF);

    // R6: requests after job end ignored
    cycle(1, 1, 0);
    cycle(1, 1, 0);
    cycle(0, 1, 0);
    check(xferStb == 1'b0, "R6 request after done", 32'(xferStb), 0);
    check(srcAddr == 24'hFFFFFF, "R6 pointer still after done", 32'(srcAddr), 32'hFFFFFF);

    // R9: reset in mid job, then R1 request ignored
    setCfg(24'h001000, 24'h002000, 2'b01, 2'b01, 1'b0, 1'b1, 8'd5, 16'd2);
    cycle(0, 0, 1);
    cycle(1, 1, 0);
    cycle(0, 1, 0);
    cycle(0, 1, 0);
    doReset();
    check(xferStb == 1'b0, "R9 mid-job reset strobe", 32'(xferStb), 0);
    check(dstAddr == 24'h0, "R9 mid-job reset pointer", 32'(dstAddr), 0);
    cycle(1, 1, 0);
    cycle(0, 1, 0);
    check(xferStb == 1'b0, "R1 request after reset", 32'(xferStb), 0);

    // R6 R2: N encoded 0 means 65536 blocks
    setCfg(24'h000100, 24'h000200, 2'b01, 2'b00, 1'b0, 1'b1, 8'd1, 16'd0);
    cycle(0, 1, 1);
    dutBlocks = 0;
    while (!mAllDone) cycle(1, 1, 0);
    cycle(0, 0, 0);
    check(dutBlocks == 65536, "R6 block count for encoding 0", 32'(dutBlocks), 65536);
    check(srcAddr == 24'h010100, "R3 source after 65536 blocks", 32'(srcAddr), 32'h010100);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule